// File: doc/BRIEF.md
# Dual-Port Memory Port Controller

This block wraps a 4K x 8 two-port memory that runs on one clock. Each of the two ports, left and right, has its own active-low chip enable, active-low semaphore select, active-low output enable, a read/write line (high reads, low writes), a 12-bit address and an 8-bit write data bus. Each port decodes its two select lines on its own. The port can then reach the memory array, reach a separate semaphore space, sit deselected, or report a forbidden selection.

Semaphore accesses do not touch the array. They go out to an external semaphore unit through a per-port interface: a request strobe, a write strobe, a 3-bit flag address, the write bit (data bit 0) and a returned flag bit. The block copies the returned flag bit into all eight data bits. Pin tri-states are modelled as a registered read-data bus plus a drive-enable flag. Array and semaphore reads appear one clock after the access cycle, together with their drive-enable flag. The ports never stall each other.

Top module: `dual_port_mem_ctrl`

## Requirements
- R1: With chip enable low and semaphore select high, a write (read/write low) stores the data at the full 12-bit address. A read of that address (read/write high, output enable low) returns the data on the read-data bus with the drive flag high in the cycle after the read.
- R2: With chip enable high and semaphore select low, the port raises its semaphore request and presents address bits [2:0] as the flag address, with write data bit 0 as the write bit. The memory array is left unchanged.
- R3: With chip enable and semaphore select both high, the port raises standby, raises no semaphore request and does not drive data in the next cycle.
- R4: With chip enable and semaphore select both low, the port raises its selection-error output in that cycle. It writes nothing to the array, raises no semaphore request and does not drive data.
- R5: A write cycle never drives read data, and a write happens only while read/write is low.
- R6: A read with output enable high does not drive data, and the read-data bus holds 0.
- R7: A semaphore read returns the external flag bit copied into all 8 data bits, with the drive flag high, one cycle after the read.
- R8: Data written through one port is returned by a later read of the same address through the other port.
- R9: If both ports write the same array address in one cycle, the right port's data is stored and the collision output is high for the following cycle only. Writes to different addresses raise no collision.
- R10: Both ports can read in the same cycle, and each gets its own result one cycle later with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ltCeN | input | 1 | Left chip enable, active low |
| ltSemN | input | 1 | Left semaphore select, active low |
| ltOeN | input | 1 | Left output enable, active low |
| ltRdWrN | input | 1 | Left read (1) / write (0) |
| ltAddr | input | 12 | Left address |
| ltWrData | input | 8 | Left write data |
| ltRdData | output | 8 | Left read data, registered |
| ltRdDrive | output | 1 | Left data drive enable, aligned with ltRdData |
| ltStandby | output | 1 | Left port deselected |
| ltSelError | output | 1 | Left forbidden selection |
| ltSemReq | output | 1 | Left semaphore access request |
| ltSemWr | output | 1 | Left semaphore write strobe |
| ltSemAddr | output | 3 | Left semaphore flag address |
| ltSemWrBit | output | 1 | Left semaphore write bit |
| ltSemRdBit | input | 1 | Left flag value from semaphore unit |
| rtCeN | input | 1 | Right chip enable, active low |
| rtSemN | input | 1 | Right semaphore select, active low |
| rtOeN | input | 1 | Right output enable, active low |
| rtRdWrN | input | 1 | Right read (1) / write (0) |
| rtAddr | input | 12 | Right address |
| rtWrData | input | 8 | Right write data |
| rtRdData | output | 8 | Right read data, registered |
| rtRdDrive | output | 1 | Right data drive enable, aligned with rtRdData |
| rtStandby | output | 1 | Right port deselected |
| rtSelError | output | 1 | Right forbidden selection |
| rtSemReq | output | 1 | Right semaphore access request |
| rtSemWr | output | 1 | Right semaphore write strobe |
| rtSemAddr | output | 3 | Right semaphore flag address |
| rtSemWrBit | output | 1 | Right semaphore write bit |
| rtSemRdBit | input | 1 | Right flag value from semaphore unit |
| collision | output | 1 | Same-address write by both ports last cycle |

## Verification
The four select combinations are each driven on both ports. After every non-memory mode, a memory read of a previously written location shows whether the array was disturbed, which separates a correct decode from one that leaks writes. Reads are tried with output enable low and high, on the same port and across ports, and with both ports at once, to tell read gating, shared storage and port independence apart. Same-address and different-address dual writes separate the collision priority and flag from ordinary parallel writes. Semaphore reads with flag values 1 and 0 check that the bit is copied to all data bits.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_MEM  = 2'd1,
    MODE_SEM  = 2'd2,
    MODE_BAD  = 2'd3
  } portMode_e;

  typedef struct packed {
    logic memWr;
    logic memRd;
    logic semWr;
    logic semRd;
  } portStrb_t;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
(
  input  logic      ceN,
  input  logic      semN,
  input  logic      oeN,
  input  logic      rdWrN,
  output portStrb_t strb,
  output logic      standby,
  output logic      selError
);
  portMode_e mode;
  logic wrEn;
  logic rdEn;

  always_comb begin
    case ({ceN, semN})
      2'b01:   mode = MODE_MEM;
      2'b10:   mode = MODE_SEM;
      2'b11:   mode = MODE_IDLE;
      default: mode = MODE_BAD;
    endcase
  end

  assign wrEn = !rdWrN;
  assign rdEn = rdWrN && !oeN;

  always_comb begin
    strb       = '0;
    strb.memWr = (mode == MODE_MEM) && wrEn;
    strb.memRd = (mode == MODE_MEM) && rdEn;
    strb.semWr = (mode == MODE_SEM) && wrEn;
    strb.semRd = (mode == MODE_SEM) && rdEn;
  end

  assign standby  = (mode == MODE_IDLE);
  assign selError = (mode == MODE_BAD);
endmodule

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int PORTS  = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  portStrb_t [PORTS-1:0]         strb,
  input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
  input  logic [PORTS-1:0][DATA_W-1:0]  wrData,
  input  logic [PORTS-1:0]              semRdBit,
  output logic [PORTS-1:0][DATA_W-1:0]  rdData,
  output logic [PORTS-1:0]              rdDrive,
  output logic                          collision
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic sameWrite;

  // Port order in the loop gives the higher index (right) the last word.
  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (strb[p].memWr) memArray[addr[p]] <= wrData[p];
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : gRead
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdData[g]  <= '0;
        rdDrive[g] <= 1'b0;
      end else if (strb[g].memRd) begin
        rdData[g]  <= memArray[addr[g]];
        rdDrive[g] <= 1'b1;
      end else if (strb[g].semRd) begin
        rdData[g]  <= {DATA_W{semRdBit[g]}};
        rdDrive[g] <= 1'b1;
      end else begin
        rdData[g]  <= '0;
        rdDrive[g] <= 1'b0;
      end
    end
  end

  assign sameWrite = strb[0].memWr && strb[PORTS-1].memWr && (addr[0] == addr[PORTS-1]);

  always_ff @(posedge clk) begin
    if (!rstN) collision <= 1'b0;
    else       collision <= sameWrite;
  end
endmodule

// File: rtl/dual_port_mem_ctrl.sv
module dual_port_mem_ctrl
  import dpm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int SEM_ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ltCeN,
  input  logic                  ltSemN,
  input  logic                  ltOeN,
  input  logic                  ltRdWrN,
  input  logic [ADDR_W-1:0]     ltAddr,
  input  logic [DATA_W-1:0]     ltWrData,
  output logic [DATA_W-1:0]     ltRdData,
  output logic                  ltRdDrive,
  output logic                  ltStandby,
  output logic                  ltSelError,
  output logic                  ltSemReq,
  output logic                  ltSemWr,
  output logic [SEM_ADDR_W-1:0] ltSemAddr,
  output logic                  ltSemWrBit,
  input  logic                  ltSemRdBit,
  input  logic                  rtCeN,
  input  logic                  rtSemN,
  input  logic                  rtOeN,
  input  logic                  rtRdWrN,
  input  logic [ADDR_W-1:0]     rtAddr,
  input  logic [DATA_W-1:0]     rtWrData,
  output logic [DATA_W-1:0]     rtRdData,
  output logic                  rtRdDrive,
  output logic                  rtStandby,
  output logic                  rtSelError,
  output logic                  rtSemReq,
  output logic                  rtSemWr,
  output logic [SEM_ADDR_W-1:0] rtSemAddr,
  output logic                  rtSemWrBit,
  input  logic                  rtSemRdBit,
  output logic                  collision
);
  localparam int PORTS = 2;

  logic [PORTS-1:0]             ceN, semN, oeN, rdWrN, standby, selError, semRdBit, rdDrive;
  logic [PORTS-1:0][ADDR_W-1:0] addr;
  logic [PORTS-1:0][DATA_W-1:0] wrData, rdData;
  portStrb_t [PORTS-1:0]        strb;

  assign ceN      = {rtCeN, ltCeN};
  assign semN     = {rtSemN, ltSemN};
  assign oeN      = {rtOeN, ltOeN};
  assign rdWrN    = {rtRdWrN, ltRdWrN};
  assign addr     = {rtAddr, ltAddr};
  assign wrData   = {rtWrData, ltWrData};
  assign semRdBit = {rtSemRdBit, ltSemRdBit};

  for (genvar g = 0; g < PORTS; g++) begin : gPort
    dpm_port_decode uDecode (
      .ceN      (ceN[g]),
      .semN     (semN[g]),
      .oeN      (oeN[g]),
      .rdWrN    (rdWrN[g]),
      .strb     (strb[g]),
      .standby  (standby[g]),
      .selError (selError[g])
    );
  end

  dpm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(PORTS)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .wrData    (wrData),
    .semRdBit  (semRdBit),
    .rdData    (rdData),
    .rdDrive   (rdDrive),
    .collision (collision)
  );

  assign ltRdData   = rdData[0];
  assign rtRdData   = rdData[1];
  assign ltRdDrive  = rdDrive[0];
  assign rtRdDrive  = rdDrive[1];
  assign ltStandby  = standby[0];
  assign rtStandby  = standby[1];
  assign ltSelError = selError[0];
  assign rtSelError = selError[1];
  assign ltSemReq   = strb[0].semWr || strb[0].semRd;
  assign rtSemReq   = strb[1].semWr || strb[1].semRd;
  assign ltSemWr    = strb[0].semWr;
  assign rtSemWr    = strb[1].semWr;
  assign ltSemAddr  = ltAddr[SEM_ADDR_W-1:0];
  assign rtSemAddr  = rtAddr[SEM_ADDR_W-1:0];
  assign ltSemWrBit = ltWrData[0];
  assign rtSemWrBit = rtWrData[0];
endmodule

// File: rtl/dual_port_mem_ctrl_chk.sv
module dual_port_mem_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ltCeN, ltSemN, ltOeN, ltRdWrN,
  input logic [ADDR_W-1:0] ltAddr,
  input logic [DATA_W-1:0] ltRdData,
  input logic              ltRdDrive, ltStandby, ltSelError, ltSemReq, ltSemRdBit,
  input logic              rtCeN, rtSemN, rtOeN, rtRdWrN,
  input logic [ADDR_W-1:0] rtAddr,
  input logic [DATA_W-1:0] rtRdData,
  input logic              rtRdDrive, rtStandby, rtSelError, rtSemReq, rtSemRdBit,
  input logic              collision
);
  logic bothMemWrSame;
  assign bothMemWrSame = !ltRdWrN && !rtRdWrN && !ltCeN && ltSemN && !rtCeN && rtSemN
                         && (ltAddr == rtAddr);

  AST_LT_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    ltRdDrive |-> $past(!ltOeN && ltRdWrN && (ltCeN != ltSemN))); // R6
  AST_RT_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rtRdDrive |-> $past(!rtOeN && rtRdWrN && (rtCeN != rtSemN))); // R6
  AST_LT_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ltSelError |-> !ltSemReq); // R4
  AST_RT_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rtSelError |-> !rtSemReq); // R4
  AST_LT_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ltStandby |=> !ltRdDrive); // R3
  AST_RT_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rtStandby |=> !rtRdDrive); // R3
  AST_LT_SEM_SPREAD: assert property (@(posedge clk) disable iff (!rstN)
    (ltRdDrive && $past(ltSemReq)) |-> (ltRdData == {DATA_W{$past(ltSemRdBit)}})); // R7
  AST_RT_SEM_SPREAD: assert property (@(posedge clk) disable iff (!rstN)
    (rtRdDrive && $past(rtSemReq)) |-> (rtRdData == {DATA_W{$past(rtSemRdBit)}})); // R7
  AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    collision |-> $past(bothMemWrSame)); // R9
  AST_COLL_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    bothMemWrSame |=> collision); // R9
endmodule

bind dual_port_mem_ctrl dual_port_mem_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN),
  .ltCeN(ltCeN), .ltSemN(ltSemN), .ltOeN(ltOeN), .ltRdWrN(ltRdWrN), .ltAddr(ltAddr),
  .ltRdData(ltRdData), .ltRdDrive(ltRdDrive), .ltStandby(ltStandby),
  .ltSelError(ltSelError), .ltSemReq(ltSemReq), .ltSemRdBit(ltSemRdBit),
  .rtCeN(rtCeN), .rtSemN(rtSemN), .rtOeN(rtOeN), .rtRdWrN(rtRdWrN), .rtAddr(rtAddr),
  .rtRdData(rtRdData), .rtRdDrive(rtRdDrive), .rtStandby(rtStandby),
  .rtSelError(rtSelError), .rtSemReq(rtSemReq), .rtSemRdBit(rtSemRdBit),
  .collision(collision)
);

// File: tb/dual_port_mem_ctrl_test.sv
module dual_port_mem_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ltCeN = 1, ltSemN = 1, ltOeN = 1, ltRdWrN = 1, ltSemRdBit = 0;
  logic rtCeN = 1, rtSemN = 1, rtOeN = 1, rtRdWrN = 1, rtSemRdBit = 0;
  logic [11:0] ltAddr = '0, rtAddr = '0;
  logic [7:0]  ltWrData = '0, rtWrData = '0;
  logic [7:0]  ltRdData, rtRdData;
  logic ltRdDrive, ltStandby, ltSelError, ltSemReq, ltSemWr, ltSemWrBit;
  logic rtRdDrive, rtStandby, rtSelError, rtSemReq, rtSemWr, rtSemWrBit;
  logic [2:0] ltSemAddr, rtSemAddr;
  logic collision;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dual_port_mem_ctrl uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // side 0 = left, 1 = right
  task automatic setPort(int side, logic ce, logic sem, logic oe, logic rw,
                         logic [11:0] a, logic [7:0] d);
    if (side == 0) begin
      ltCeN = ce; ltSemN = sem; ltOeN = oe; ltRdWrN = rw; ltAddr = a; ltWrData = d;
    end else begin
      rtCeN = ce; rtSemN = sem; rtOeN = oe; rtRdWrN = rw; rtAddr = a; rtWrData = d;
    end
  endtask

  task automatic idleBoth();
    setPort(0, 1, 1, 1, 1, 0, 0);
    setPort(1, 1, 1, 1, 1, 0, 0);
  endtask

  task automatic memWrite(int side, logic [11:0] a, logic [7:0] d);
    setPort(side, 0, 1, 1, 0, a, d);
    step();
    idleBoth();
  endtask

  task automatic memReadCheck(int side, logic [11:0] a, logic [7:0] exp, string req);
    setPort(side, 0, 1, 0, 1, a, 0);
    step();
    idleBoth();
    if (side == 0) begin
      chk(req, ltRdData, exp); chk(req, ltRdDrive, 1);
    end else begin
      chk(req, rtRdData, exp); chk(req, rtRdDrive, 1);
    end
  endtask

  task automatic testReset();
    chk("reset", ltRdDrive, 0);
    chk("reset", rtRdDrive, 0);
    chk("reset", collision, 0);
    chk("reset R3", ltStandby, 1);
  endtask

  task automatic testMemRw();
    setPort(0, 0, 1, 0, 0, 12'h123, 8'hA5);
    step();
    chk("R5 write no drive", ltRdDrive, 0);
    idleBoth();
    memReadCheck(0, 12'h123, 8'hA5, "R1");
    memWrite(0, 12'hFFF, 8'h3C);
    memReadCheck(0, 12'hFFF, 8'h3C, "R1 top addr");
    memWrite(0, 12'h125, 8'h11);
  endtask

  task automatic testOeHigh();
    setPort(0, 0, 1, 1, 1, 12'h123, 0);
    step();
    idleBoth();
    chk("R6 drive", ltRdDrive, 0);
    chk("R6 data", ltRdData, 0);
  endtask

  task automatic testCross();
    memReadCheck(1, 12'h123, 8'hA5, "R8 left-to-right");
    memWrite(1, 12'h040, 8'h77);
    memReadCheck(0, 12'h040, 8'h77, "R8 right-to-left");
  endtask

  task automatic testParallel();
    setPort(0, 0, 1, 0, 1, 12'h123, 0);
    setPort(1, 0, 1, 0, 1, 12'hFFF, 0);
    step();
    idleBoth();
    chk("R10 left", ltRdData, 8'hA5);
    chk("R10 right", rtRdData, 8'h3C);
    chk("R10 drive", {ltRdDrive, rtRdDrive}, 2'b11);
  endtask

  task automatic testSem();
    setPort(0, 1, 0, 1, 0, 12'h125, 8'h00);
    #1;
    chk("R2 req", ltSemReq, 1);
    chk("R2 wr", ltSemWr, 1);
    chk("R2 addr", ltSemAddr, 3'd5);
    chk("R2 bit", ltSemWrBit, 0);
    step();
    chk("R5 sem write no drive", ltRdDrive, 0);
    idleBoth();
    memReadCheck(0, 12'h125, 8'h11, "R2 array untouched");
    rtSemRdBit = 1;
    ltSemRdBit = 0;
    setPort(1, 1, 0, 0, 1, 12'h002, 0);
    setPort(0, 1, 0, 0, 1, 12'h007, 0);
    #1;
    chk("R2 read req", rtSemReq, 1);
    chk("R2 read no wr", rtSemWr, 0);
    step();
    idleBoth();
    chk("R7 spread one", rtRdData, 8'hFF);
    chk("R7 drive", rtRdDrive, 1);
    chk("R7 spread zero", ltRdData, 8'h00);
    chk("R7 drive", ltRdDrive, 1);
  endtask

  task automatic testDeselect();
    setPort(0, 1, 1, 0, 1, 12'h123, 0);
    #1;
    chk("R3 standby", ltStandby, 1);
    chk("R3 no req", ltSemReq, 0);
    step();
    idleBoth();
    chk("R3 no drive", ltRdDrive, 0);
  endtask

  task automatic testBadSelect();
    setPort(0, 0, 0, 1, 0, 12'h123, 8'hEE);
    #1;
    chk("R4 error", ltSelError, 1);
    chk("R4 no req", ltSemReq, 0);
    chk("R4 not standby", ltStandby, 0);
    step();
    idleBoth();
    #1;
    chk("R4 error clears", ltSelError, 0);
    memReadCheck(0, 12'h123, 8'hA5, "R4 array untouched");
    setPort(1, 0, 0, 0, 1, 12'h123, 0);
    step();
    idleBoth();
    chk("R4 bad read no drive", rtRdDrive, 0);
  endtask

  task automatic testCollide();
    setPort(0, 0, 1, 1, 0, 12'h200, 8'h11);
    setPort(1, 0, 1, 1, 0, 12'h200, 8'h22);
    step();
    idleBoth();
    chk("R9 pulse", collision, 1);
    step();
    chk("R9 single pulse", collision, 0);
    memReadCheck(0, 12'h200, 8'h22, "R9 right wins");
    setPort(0, 0, 1, 1, 0, 12'h300, 8'h33);
    setPort(1, 0, 1, 1, 0, 12'h301, 8'h44);
    step();
    idleBoth();
    chk("R9 distinct no flag", collision, 0);
    memReadCheck(1, 12'h300, 8'h33, "R9 distinct left");
    memReadCheck(0, 12'h301, 8'h44, "R9 distinct right");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d cycles expected=fewer", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMemRw();
    testOeHigh();
    testCross();
    testParallel();
    testSem();
    testDeselect();
    testBadSelect();
    testCollide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule